// File: doc/BRIEF.md
# Delayed Sweep Gating Controller

This block decides when a second, delayed sweep (B) may start during a main sweep (A). While an A sweep runs, a digital value of the A ramp is compared each cycle with a programmable delay level. Once the ramp reaches that level, an active-low delay gate goes low. The delay gate arms the B start logic, which then works in one of two modes. In triggered mode the B sweep waits for a B trigger event that arrives after the delay. In free mode the B sweep starts in the same cycle the delay gate falls.

The block also keeps a small status word built from live sweep state and sticky event flags. A host reads this word one bit per strobe pulse on a single serial output line. The host uses it to spot missing triggers for automatic level and free-run handling, and to see when a single-sequence acquisition has finished. The analog ramp and the analog comparators are outside this block.

Top module: `dly_sweep_ctrl`

## Requirements
- R1: When the A sweep is active and `ramp_i >= dly_ref_i` is sampled at a rising edge, `dly_gate_n_o` is low after that edge. It stays low until the A sweep ends.
- R2: Before an A sweep begins (`a_start_i` sampled high), the ramp comparison has no effect. `dly_gate_n_o` stays high even when the ramp is above the delay level.
- R3: In triggered mode (`free_run_i` = 0), `b_gate_n_o` goes low after the edge that samples `b_trig_i` high while `dly_gate_n_o` is already low. A B trigger sampled while `dly_gate_n_o` is high is ignored.
- R4: In free mode (`free_run_i` = 1), `b_gate_n_o` falls in the same cycle as `dly_gate_n_o`, and no B trigger is needed.
- R5: `a_end_i` sampled high returns both `dly_gate_n_o` and `b_gate_n_o` high after that edge. If `a_end_i` and `a_start_i` are high together, `a_end_i` wins.
- R6: A read burst has 8 strobes. The first strobe of a burst latches a snapshot of the status word. After the k-th strobe edge (k = 1..8), `sts_o` carries snapshot bit k-1, so the word is sent LSB first. `sts_o` changes only on strobe edges.
- R7: Status word bits: 0 = A sweep active, 1 = delay reached, 2 = B sweep running, 3 = B trigger seen (sticky), 4 = A sweep ended (sticky), 5 = A sweep ended with the delay reached but no B sweep (sticky), 6 = B sweep completed (sticky), 7 = current mode select.
- R8: The first strobe of a burst clears the sticky bits 3 to 6 after they are captured. An event that occurs in that same cycle stays set for the next read.
- R9: Asynchronous reset puts both gates high, `sts_o` low, all sticky bits clear and the strobe count at the start of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ramp_i | input | RAMP_W | Digitised A sweep ramp value |
| dly_ref_i | input | RAMP_W | Delay level to compare against |
| free_run_i | input | 1 | Mode select: 1 = start B when delay expires, 0 = wait for B trigger |
| b_trig_i | input | 1 | B trigger event, one cycle per event |
| a_start_i | input | 1 | A sweep start pulse |
| a_end_i | input | 1 | A sweep end pulse |
| stb_i | input | 1 | Status read strobe, one cycle per bit |
| dly_gate_n_o | output | 1 | Delay gate, low once the delay level has been reached |
| b_gate_n_o | output | 1 | B sweep gate, low while the B sweep runs |
| sts_o | output | 1 | Serial status bit |

## Verification
The properties assume that the mode select does not change in the cycle a gate falls. They also assume that strobes come only as single-cycle pulses and that a read burst is always completed to 8 strobes. The stimulus changes the mode only between sweeps, while both gates are high. It issues strobes through a read task that always sends a whole burst, with idle cycles between pulses. Sweeps drive the ramp upward one step per cycle, between clean start and end pulses, and B triggers are placed both before and after the delay point.

// File: rtl/dsg_pkg.sv
package dsg_pkg;
  localparam int STS_W   = 8;
  localparam int STS_CW  = $clog2(STS_W);

  // status word bit positions (host decodes these)
  localparam int SB_A_ACT   = 0;
  localparam int SB_DLY     = 1;
  localparam int SB_B_RUN   = 2;
  localparam int SB_TRIG    = 3;
  localparam int SB_A_DONE  = 4;
  localparam int SB_B_MISS  = 5;
  localparam int SB_B_DONE  = 6;
  localparam int SB_MODE    = 7;
  localparam int SB_STK_LO  = SB_TRIG;
  localparam int SB_STK_HI  = SB_B_DONE;
  localparam int STK_N      = SB_STK_HI - SB_STK_LO + 1;

  typedef logic [STS_W-1:0] sts_vec_t;
  typedef logic [STK_N-1:0] stk_vec_t;
endpackage

// File: rtl/dsg_rst_sync.sv
module dsg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dsg_delay_cmp.sv
module dsg_delay_cmp #(
  parameter int RAMP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RAMP_W-1:0] ramp_i,
  input  logic [RAMP_W-1:0] dly_ref_i,
  input  logic              a_start_i,
  input  logic              a_end_i,
  output logic              act_o,
  output logic              dly_o,
  output logic              dly_next_o
);
  logic act_q, act_d;
  logic dly_q, dly_d;
  logic hit;

  always_comb begin
    hit   = act_q && (ramp_i >= dly_ref_i);
    act_d = act_q;
    dly_d = dly_q;
    if (a_end_i) begin
      act_d = 1'b0;
      dly_d = 1'b0;
    end else begin
      if (a_start_i) act_d = 1'b1;
      if (hit)       dly_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      dly_q <= 1'b0;
    end else begin
      act_q <= act_d;
      dly_q <= dly_d;
    end
  end

  assign act_o      = act_q;
  assign dly_o      = dly_q;
  assign dly_next_o = dly_d;
endmodule

// File: rtl/dsg_bgate.sv
module dsg_bgate (
  input  logic clk,
  input  logic rst_n,
  input  logic free_run_i,
  input  logic b_trig_i,
  input  logic a_end_i,
  input  logic dly_q_i,
  input  logic dly_next_i,
  output logic bsw_o
);
  logic bsw_q, bsw_d;
  logic arm;

  always_comb begin
    // free mode follows the delay gate; triggered mode needs a trigger after it
    arm   = free_run_i ? dly_next_i : (dly_q_i && b_trig_i);
    bsw_d = bsw_q;
    if (a_end_i)  bsw_d = 1'b0;
    else if (arm) bsw_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bsw_q <= 1'b0;
    else        bsw_q <= bsw_d;
  end

  assign bsw_o = bsw_q;
endmodule

// File: rtl/dsg_status.sv
module dsg_status
  import dsg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  input  logic act_i,
  input  logic dly_i,
  input  logic bsw_i,
  input  logic mode_i,
  input  logic b_trig_i,
  input  logic a_end_i,
  output logic sts_o
);
  stk_vec_t               stk_q, stk_d, stk_set;
  logic [STS_CW-1:0]      cnt_q, cnt_d;
  logic [STS_W-2:0]       sh_q, sh_d;
  logic                   out_q, out_d;
  logic                   first;
  sts_vec_t               snap;

  always_comb begin
    snap            = '0;
    snap[SB_A_ACT]  = act_i;
    snap[SB_DLY]    = dly_i;
    snap[SB_B_RUN]  = bsw_i;
    snap[SB_MODE]   = mode_i;
    snap[SB_STK_HI:SB_STK_LO] = stk_q;
  end

  always_comb begin
    stk_set                        = '0;
    stk_set[SB_TRIG   - SB_STK_LO] = b_trig_i;
    stk_set[SB_A_DONE - SB_STK_LO] = a_end_i && act_i;
    stk_set[SB_B_MISS - SB_STK_LO] = a_end_i && act_i && dly_i && !bsw_i;
    stk_set[SB_B_DONE - SB_STK_LO] = a_end_i && bsw_i;
  end

  always_comb begin
    first = stb_i && (cnt_q == '0);
    cnt_d = cnt_q;
    sh_d  = sh_q;
    out_d = out_q;
    stk_d = stk_q;
    if (first) stk_d = '0;
    stk_d = stk_d | stk_set;
    if (stb_i) begin
      if (cnt_q == STS_CW'(STS_W - 1)) cnt_d = '0;
      else                             cnt_d = cnt_q + 1'b1;
      if (first) begin
        out_d = snap[0];
        sh_d  = snap[STS_W-1:1];
      end else begin
        out_d = sh_q[0];
        sh_d  = {1'b0, sh_q[STS_W-2:1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk_q <= '0;
      cnt_q <= '0;
      sh_q  <= '0;
      out_q <= 1'b0;
    end else begin
      stk_q <= stk_d;
      if (stb_i) begin
        cnt_q <= cnt_d;
        sh_q  <= sh_d;
        out_q <= out_d;
      end
    end
  end

  assign sts_o = out_q;
endmodule

// File: rtl/dly_sweep_ctrl.sv
module dly_sweep_ctrl #(
  parameter int RAMP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RAMP_W-1:0] ramp_i,
  input  logic [RAMP_W-1:0] dly_ref_i,
  input  logic              free_run_i,
  input  logic              b_trig_i,
  input  logic              a_start_i,
  input  logic              a_end_i,
  input  logic              stb_i,
  output logic              dly_gate_n_o,
  output logic              b_gate_n_o,
  output logic              sts_o
);
  logic rst_n_s;
  logic act, dly, dly_next, bsw;

  dsg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_s)
  );

  dsg_delay_cmp #(.RAMP_W(RAMP_W)) u_cmp (
    .clk(clk), .rst_n(rst_n_s), .ramp_i(ramp_i), .dly_ref_i(dly_ref_i),
    .a_start_i(a_start_i), .a_end_i(a_end_i),
    .act_o(act), .dly_o(dly), .dly_next_o(dly_next)
  );

  dsg_bgate u_bg (
    .clk(clk), .rst_n(rst_n_s), .free_run_i(free_run_i), .b_trig_i(b_trig_i),
    .a_end_i(a_end_i), .dly_q_i(dly), .dly_next_i(dly_next), .bsw_o(bsw)
  );

  dsg_status u_sts (
    .clk(clk), .rst_n(rst_n_s), .stb_i(stb_i), .act_i(act), .dly_i(dly),
    .bsw_i(bsw), .mode_i(free_run_i), .b_trig_i(b_trig_i), .a_end_i(a_end_i),
    .sts_o(sts_o)
  );

  assign dly_gate_n_o = ~dly;
  assign b_gate_n_o   = ~bsw;
endmodule

// File: rtl/dly_sweep_ctrl_chk.sv
module dly_sweep_ctrl_chk #(
  parameter int RAMP_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [RAMP_W-1:0] ramp_i,
  input logic [RAMP_W-1:0] dly_ref_i,
  input logic              free_run_i,
  input logic              b_trig_i,
  input logic              a_end_i,
  input logic              stb_i,
  input logic              dly_gate_n_o,
  input logic              b_gate_n_o,
  input logic              sts_o
);
  p_dly_cond_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dly_gate_n_o) |-> $past(ramp_i >= dly_ref_i));

  p_b_after_dly_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !b_gate_n_o |-> !dly_gate_n_o);

  p_trig_needed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(b_gate_n_o) && !$past(free_run_i)) |-> ($past(b_trig_i) && !$past(dly_gate_n_o)));

  p_free_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dly_gate_n_o) && $past(free_run_i)) |-> $fell(b_gate_n_o));

  p_end_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    a_end_i |=> (dly_gate_n_o && b_gate_n_o));

  p_sts_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> $stable(sts_o));
endmodule

bind dly_sweep_ctrl dly_sweep_ctrl_chk #(.RAMP_W(RAMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ramp_i(ramp_i), .dly_ref_i(dly_ref_i),
  .free_run_i(free_run_i), .b_trig_i(b_trig_i), .a_end_i(a_end_i),
  .stb_i(stb_i), .dly_gate_n_o(dly_gate_n_o), .b_gate_n_o(b_gate_n_o),
  .sts_o(sts_o)
);

// File: tb/dly_sweep_ctrl_tb.sv
module dly_sweep_ctrl_tb;
  localparam int RW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [RW-1:0] ramp = '0;
  logic [RW-1:0] dref = '0;
  logic          free_run = 1'b0, btrig = 1'b0, a_start = 1'b0, a_end = 1'b0, stb = 1'b0;
  logic          dgate_n, bgate_n, sts;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dly_sweep_ctrl #(.RAMP_W(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ramp_i(ramp), .dly_ref_i(dref),
    .free_run_i(free_run), .b_trig_i(btrig), .a_start_i(a_start),
    .a_end_i(a_end), .stb_i(stb), .dly_gate_n_o(dgate_n),
    .b_gate_n_o(bgate_n), .sts_o(sts)
  );

  // behavioural reference model
  bit m_act, m_dly, m_bsw, m_out;
  bit m_stk[7];
  int m_cnt;
  bit m_bits[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_dly = 0; m_bsw = 0; m_out = 0; m_cnt = 0;
      for (int i = 0; i < 7; i++) m_stk[i] = 0;
      m_bits.delete();
    end else begin
      bit snap[8];
      bit nd, nb, na;
      snap[0] = m_act; snap[1] = m_dly; snap[2] = m_bsw;
      for (int i = 3; i < 7; i++) snap[i] = m_stk[i];
      snap[7] = free_run;
      if (stb) begin
        if (m_cnt == 0) begin
          m_bits.delete();
          for (int i = 1; i < 8; i++) m_bits.push_back(snap[i]);
          m_out = snap[0];
          for (int i = 3; i < 7; i++) m_stk[i] = 0;
        end else m_out = m_bits.pop_front();
        m_cnt = (m_cnt + 1) % 8;
      end
      if (btrig) m_stk[3] = 1;
      if (a_end && m_act) m_stk[4] = 1;
      if (a_end && m_act && m_dly && !m_bsw) m_stk[5] = 1;
      if (a_end && m_bsw) m_stk[6] = 1;
      if (a_end) begin na = 0; nd = 0; nb = 0; end
      else begin
        na = m_act || a_start;
        nd = m_dly || (m_act && ramp >= dref);
        nb = m_bsw || (free_run ? nd : (m_dly && btrig));
      end
      m_act = na; m_dly = nd; m_bsw = nb;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare with the model on every clock, away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk("R1 delay gate", dgate_n, !m_dly);
    chk(free_run ? "R4 B gate" : "R3 B gate", bgate_n, !m_bsw);
    chk("R6 serial bit", sts, m_out);
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic read_sts(output logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      stb = 1'b1; tick(); stb = 1'b0;
      v[i] = sts;
      tick();
    end
  endtask

  // A sweep: ramp rises 1 per cycle; btrig pulses at listed ramp values
  task automatic sweep(input bit fr, input int lvl, input int len, input int t1, input int t2);
    free_run = fr; dref = RW'(lvl);
    ramp = '0; a_start = 1'b1; tick(); a_start = 1'b0;
    for (int r = 0; r < len; r++) begin
      ramp = RW'(r);
      btrig = (r == t1) || (r == t2);
      tick();
      if (r == t1 && t1 < lvl && !fr) chk("R3 early trigger ignored", bgate_n, 1);
    end
    btrig = 1'b0;
    a_end = 1'b1; tick(); a_end = 1'b0;
    chk("R5 gates released", {dgate_n, bgate_n}, 2'b11);
    tick();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) tick();
    chk("R9 reset delay gate", dgate_n, 1);
    chk("R9 reset B gate", bgate_n, 1);
    chk("R9 reset status", sts, 0);
    rst_n = 1'b1;
    repeat (4) tick();

    // R2: ramp above level with no sweep running
    dref = RW'(5); ramp = RW'(100);
    repeat (3) tick();
    chk("R2 no sweep no gate", dgate_n, 1);
    ramp = '0;

    read_sts(v);
    chk("R7 idle status", v, 8'h00);

    // triggered mode: early trigger (ramp 2) ignored, late one (ramp 15) starts B
    sweep(1'b0, 10, 30, 2, 15);
    read_sts(v);
    chk("R7 triggered sweep status", v, 8'h58);
    read_sts(v);
    chk("R8 sticky cleared", v, 8'h00);

    // free mode, no trigger
    sweep(1'b1, 8, 20, -1, -1);
    read_sts(v);
    chk("R7 free sweep status", v, 8'hD0);

    // triggered mode, trigger only before delay: B missed
    sweep(1'b0, 12, 25, 3, -1);
    read_sts(v);
    chk("R7 missed B status", v, 8'h38);

    // read during a running sweep: live bits and sticky kept when event coincides
    free_run = 1'b0; dref = RW'(4); ramp = RW'(9);
    a_start = 1'b1; tick(); a_start = 1'b0;
    tick(); tick();
    btrig = 1'b1; stb = 1'b1; tick(); btrig = 1'b0; stb = 1'b0;
    chk("R6 first bit A active", sts, 1);
    tick();
    for (int i = 1; i < 8; i++) begin stb = 1'b1; tick(); stb = 1'b0; tick(); end
    read_sts(v);
    chk("R8 same-cycle event kept", v, 8'h0F);

    // end and start together: end wins
    a_end = 1'b1; a_start = 1'b1; tick(); a_end = 1'b0; a_start = 1'b0;
    chk("R5 end wins", {dgate_n, bgate_n}, 2'b11);
    repeat (3) tick();
    chk("R5 sweep stays off", dgate_n, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule